// File: doc/BRIEF.md
# Dual-Port Buffer Contention Arbiter

The block arbitrates between two users of one small byte buffer. One is a serial port whose accesses come at fixed points in a repeating timeslot. The other is a parallel host port whose accesses arrive at any time. The serial side reads or writes one cell near the end of every channel timeslot. The host can hit the same cell at that moment. When it does, the arbiter defers the host access until the serial access has finished, so the serial side always goes first.

The block runs on a clock at twice the serial bit-clock rate, so each tick is one half-period of that clock. An upstream address mapper supplies the tick position within the slot and the cell that the serial side is addressing. The host strobe and chip select come from another clock domain and are resynchronized on the way in. The stall shows up in one of three ways, chosen by a mode input:
- **Handshake mode:** the data acknowledge is delayed.
- **Busy mode:** a BUSY flag is raised.
- **Synchronous mode:** there is no contention, because the host bus is timed from the serial clocks, so the block grants at once.

Each host access leaves the block as a one-cycle grant carrying the cell address and the write flag. The buffer array acts on that grant.

Top module: `dpb_contention_arb`

## Requirements
- R1: A host access whose cell differs from `ser_addr_i` is never stalled, even when it starts inside the window. In handshake mode it is granted in its decision cycle. In busy mode `busy_o` stays low.
- R2: In modes 00 and 01, `grant_o` is never high in a cycle where the phase is PHASES-1 and `grant_addr_o` equals `ser_addr_i`.
- R3: Mode 00 (handshake), window start on the same cell. The window is phases PHASES-2 and PHASES-1. The grant comes in the first cycle of the next slot (phase 0). `dtack_o` rises the cycle after the grant and stays high until the cycle in which the lowered strobe is seen.
- R4: Mode 00, start outside the window. The grant comes in the decision cycle and `dtack_o` follows one cycle later.
- R5: Mode 01 (busy), start inside the window on the same cell. `busy_o` is high from the decision cycle through phase 0. The grant comes at phase 0, and `busy_o` is low the cycle after.
- R6: Mode 01, the access starts before the window and its end is seen at phase PHASES-2. The access is granted then and `busy_o` never rises.
- R7: Mode 01, the access is still open at phase PHASES-1 on the same cell. `busy_o` is high at that phase and at the following phase 0. The grant comes at phase 0.
- R8: Mode 01, uncontended access. The grant comes in the cycle where the dropped strobe is seen. There is exactly one grant per access.
- R9: Modes 10 and 11 (synchronous). The grant comes in the decision cycle whatever the phase or cell. `busy_o` and `dtack_o` stay low.
- R10: Strobe and select each pass through two flops. The decision cycle is two cycles after the strobe rises. With select low, a strobe pulse produces no grant, BUSY or acknowledge.
- R11: While reset is held, `grant_o`, `busy_o` and `dtack_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-period tick clock of the serial timing |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 handshake, 01 busy, 10/11 synchronous |
| slot_phase_i | input | PW | Tick position within the channel slot, from the mapper |
| ser_addr_i | input | AW | Cell addressed by the serial side this slot |
| host_cs_i | input | 1 | Host chip select, asynchronous |
| host_strb_i | input | 1 | Host access strobe, asynchronous |
| host_wr_i | input | 1 | Host write flag, held stable while strobe is high |
| host_addr_i | input | AW | Host cell address, held stable while strobe is high |
| dtack_o | output | 1 | Data acknowledge (handshake mode) |
| busy_o | output | 1 | Stall flag (busy mode) |
| grant_o | output | 1 | One-cycle grant of the host access to the buffer |
| grant_wr_o | output | 1 | Write flag of the granted access |
| grant_addr_o | output | AW | Cell of the granted access |

## Verification
In each mode, accesses are placed before the window, in its first half, in its second half and well clear of it. Their lengths are chosen so that the end lands on either side of the serial tick. This separates the three busy-mode outcomes from each other and from the handshake deferral. Every contended pattern is repeated with a different cell, which shows that stalls depend on the cell match and not on timing alone. Random accesses across all modes, phases and lengths are checked against per-case predictions of the grant cycle, the BUSY span and the acknowledge span. Directed cases cover the synchronous mode inside the window and a select-low strobe.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_OPEN,
    ST_WAIT,
    ST_DONE
  } arb_state_e;

  localparam logic [1:0] MODE_HS   = 2'b00;
  localparam logic [1:0] MODE_BUSY = 2'b01;
endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/arb_window.sv
module arb_window #(
  parameter int PHASES = 16,
  parameter int PW     = $clog2(PHASES)
) (
  input  logic [PW-1:0] phase_i,
  output logic          win_o,
  output logic          ser_o,
  output logic          start_o
);
  localparam logic [PW-1:0] LAST  = PW'(PHASES - 1);
  localparam logic [PW-1:0] FIRST = PW'(PHASES - 2);

  // window = last full serial clock period: two ticks
  assign ser_o   = (phase_i == LAST);
  assign win_o   = (phase_i == FIRST) || ser_o;
  assign start_o = (phase_i == '0);
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
  import arb_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          req_i,
  input  logic          win_i,
  input  logic          ser_i,
  input  logic          start_i,
  input  logic [AW-1:0] ser_addr_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic          host_wr_i,
  output logic          dtack_o,
  output logic          busy_o,
  output logic          grant_o,
  output logic          grant_wr_o,
  output logic [AW-1:0] grant_addr_o
);
  arb_state_e    st_q, st_d;
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;
  logic          rise, hit, is_hs, is_busy;
  logic [AW-1:0] acc_addr;

  assign is_hs    = (mode_i == MODE_HS);
  assign is_busy  = (mode_i == MODE_BUSY);
  assign rise     = req_i && !req_q;
  assign acc_addr = (st_q == ST_IDLE) ? host_addr_i : addr_q;
  assign hit      = (acc_addr == ser_addr_i);

  always_comb begin
    st_d    = st_q;
    grant_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (rise) begin
        if (is_hs) begin
          if (win_i && hit) st_d = ST_WAIT;
          else begin grant_o = 1'b1; st_d = ST_DONE; end
        end else if (is_busy) begin
          st_d = (win_i && hit) ? ST_WAIT : ST_OPEN;
        end else begin
          grant_o = 1'b1;
          st_d    = ST_DONE;
        end
      end
      // busy mode: access in flight, performed when strobe ends
      ST_OPEN: begin
        if (ser_i && hit) st_d = ST_WAIT;
        else if (!req_i) begin grant_o = 1'b1; st_d = ST_IDLE; end
      end
      ST_WAIT: if (start_i) begin
        grant_o = 1'b1;
        st_d    = ST_DONE;
      end
      ST_DONE: if (!req_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      req_q  <= 1'b0;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_i;
      if (st_q == ST_IDLE && rise) begin
        addr_q <= host_addr_i;
        wr_q   <= host_wr_i;
      end
    end
  end

  assign grant_addr_o = acc_addr;
  assign grant_wr_o   = (st_q == ST_IDLE) ? host_wr_i : wr_q;
  assign dtack_o      = is_hs && (st_q == ST_DONE);
  assign busy_o       = is_busy && ((st_q == ST_WAIT) || (st_d == ST_WAIT));
endmodule

// File: rtl/dpb_contention_arb.sv
module dpb_contention_arb #(
  parameter int CELLS       = 32,
  parameter int PHASES      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(CELLS),
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [PW-1:0] slot_phase_i,
  input  logic [AW-1:0] ser_addr_i,
  input  logic          host_cs_i,
  input  logic          host_strb_i,
  input  logic          host_wr_i,
  input  logic [AW-1:0] host_addr_i,
  output logic          dtack_o,
  output logic          busy_o,
  output logic          grant_o,
  output logic          grant_wr_o,
  output logic [AW-1:0] grant_addr_o
);
  logic [1:0] sync_q;
  logic       req, win, ser, start;

  arb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_cs_i, host_strb_i}),
    .q_o   (sync_q)
  );

  assign req = sync_q[1] && sync_q[0];

  arb_window #(.PHASES(PHASES), .PW(PW)) u_win (
    .phase_i(slot_phase_i),
    .win_o  (win),
    .ser_o  (ser),
    .start_o(start)
  );

  arb_fsm #(.AW(AW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode_i),
    .req_i       (req),
    .win_i       (win),
    .ser_i       (ser),
    .start_i     (start),
    .ser_addr_i  (ser_addr_i),
    .host_addr_i (host_addr_i),
    .host_wr_i   (host_wr_i),
    .dtack_o     (dtack_o),
    .busy_o      (busy_o),
    .grant_o     (grant_o),
    .grant_wr_o  (grant_wr_o),
    .grant_addr_o(grant_addr_o)
  );
endmodule

// File: rtl/dpb_contention_arb_chk.sv
module dpb_contention_arb_chk #(
  parameter int PHASES = 16,
  parameter int AW     = 5,
  parameter int PW     = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    mode_i,
  input logic [PW-1:0] slot_phase_i,
  input logic [AW-1:0] ser_addr_i,
  input logic          dtack_o,
  input logic          busy_o,
  input logic          grant_o,
  input logic [AW-1:0] grant_addr_o
);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  AST_SER_PRIORITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !mode_i[1] && slot_phase_i == LAST) |-> (grant_addr_o != ser_addr_i)); // R2
  AST_BUSY_MODE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mode_i == 2'b01)); // R5
  AST_DTACK_MODE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dtack_o |-> (mode_i == 2'b00)); // R3
  AST_BUSY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && grant_o && slot_phase_i == '0) |=> !busy_o); // R7
  AST_SYNC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |-> (!busy_o && !dtack_o)); // R9
  AST_GRANT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o); // R8
endmodule

bind dpb_contention_arb dpb_contention_arb_chk #(
  .PHASES(PHASES), .AW(AW), .PW(PW)
) u_chk (.*);

// File: tb/dpb_contention_arb_test.sv
`timescale 1ns/1ps
module dpb_contention_arb_test;
  localparam int N  = 16;
  localparam int AW = 5;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [PW-1:0] slot_phase = '0;
  logic [AW-1:0] ser_addr = '0;
  logic          host_cs = 1'b0, host_strb = 1'b0, host_wr = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic          dtack, busy, grant, grant_wr;
  logic [AW-1:0] grant_addr;

  int ph = 0;
  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  dpb_contention_arb #(.CELLS(32), .PHASES(N), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .slot_phase_i(slot_phase),
    .ser_addr_i(ser_addr), .host_cs_i(host_cs), .host_strb_i(host_strb),
    .host_wr_i(host_wr), .host_addr_i(host_addr), .dtack_o(dtack),
    .busy_o(busy), .grant_o(grant), .grant_wr_o(grant_wr), .grant_addr_o(grant_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one cycle: new phase at negedge, outputs sampled 1 ns later
  task automatic tick();
    @(negedge clk);
    ph = (ph + 1) % N;
    slot_phase = PW'(ph);
    #1;
  endtask

  function automatic int hs_grant(input int p0, input bit hit);
    int d = (p0 + 2) % N;
    if (hit && d >= N - 2) return 2 + N - d;
    return 2;
  endfunction

  function automatic void busy_exp(input int p0, input int len, input bit hit,
                                   output int g, output int b0, output int b1);
    int d = (p0 + 2) % N;
    b0 = -1; b1 = -2;
    if (hit && d >= N - 2) begin
      g = 2 + N - d; b0 = 2; b1 = g;
      return;
    end
    for (int c = 3; c <= len + 2; c++) begin
      if (hit && ((p0 + c) % N) == N - 1) begin
        g = c + 1; b0 = c; b1 = c + 1;
        return;
      end
    end
    g = len + 2;
  endfunction

  task automatic access(input logic [1:0] m, input int p0, input int len,
                        input bit hit, input logic [AW-1:0] a, input bit wr);
    int g, b0, b1, lact, horizon, d;
    int n_grant, g_at, busy_bad, dt_bad, g_ph;
    logic [AW-1:0] g_addr;
    bit g_wr;
    string tag;
    d = (p0 + 2) % N;
    mode = m;
    ser_addr = hit ? a : a ^ 5'd1;
    lact = len;
    b0 = -1; b1 = -2;
    if (m == 2'b00) begin
      g = hs_grant(p0, hit);
      if (lact < g) lact = g;
      tag = (hit && d >= N - 2) ? "R3" : ((d >= N - 2) ? "R1" : "R4");
    end else if (m == 2'b01) begin
      busy_exp(p0, len, hit, g, b0, b1);
      if (hit && d >= N - 2) tag = "R5";
      else if (b0 >= 0) tag = "R7";
      else if (hit && ((p0 + len + 2) % N) == N - 2) tag = "R6";
      else if (d >= N - 2) tag = "R1";
      else tag = "R8";
    end else begin
      g = 2;
      tag = "R9";
    end
    // wait so that the raise cycle carries phase p0
    while (((ph + 1) % N) != p0) tick();
    n_grant = 0; g_at = -1; busy_bad = 0; dt_bad = 0; g_ph = -1;
    g_addr = '0; g_wr = 1'b0;
    horizon = lact + 2 * N + 6;
    for (int k = 0; k <= horizon; k++) begin
      @(negedge clk);
      ph = (ph + 1) % N;
      slot_phase = PW'(ph);
      if (k == 0) begin
        host_addr = a; host_wr = wr; host_cs = 1'b1; host_strb = 1'b1;
      end
      if (k == lact) begin
        host_strb = 1'b0; host_cs = 1'b0;
      end
      #1;
      if (grant) begin
        n_grant++;
        if (g_at < 0) begin g_at = k; g_addr = grant_addr; g_wr = grant_wr; g_ph = ph; end
      end
      if (busy != (k >= b0 && k <= b1 && b0 >= 0)) busy_bad++;
      if (dtack != (m == 2'b00 && k >= g + 1 && k <= lact + 2)) dt_bad++;
    end
    check(n_grant == 1, tag, "grant count", n_grant, 1);
    check(g_at == g, tag, "grant cycle", g_at, g);
    check(g_addr == a && g_wr == wr, tag, "grant addr/wr", {g_addr, g_wr}, {a, wr});
    check(busy_bad == 0, tag, "busy span mismatches", busy_bad, 0);
    check(dt_bad == 0, tag, "dtack span mismatches", dt_bad, 0);
    if (!m[1] && hit)
      check(g_ph != N - 1, "R2", "grant phase on serial tick", g_ph, N);
    if (m == 2'b10 && p0 == N - 3)
      check(g_at == 2, "R10", "decision two cycles after strobe", g_at, 2);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired: actual=0 expected=1");
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) tick();
    check(!grant && !busy && !dtack, "R11", "outputs in reset", {grant, busy, dtack}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) tick();

    // handshake
    access(2'b00, N - 4, 3, 1'b1, 5'd7, 1'b1);   // R3 start at first window half
    access(2'b00, N - 3, 3, 1'b1, 5'd9, 1'b0);   // R3 start at serial tick
    access(2'b00, N - 4, 3, 1'b0, 5'd7, 1'b1);   // R1 different cell
    access(2'b00, 2, 5, 1'b1, 5'd3, 1'b0);       // R4
    // busy
    access(2'b01, N - 3, 4, 1'b1, 5'd12, 1'b1);  // R5
    access(2'b01, N - 7, 3, 1'b1, 5'd4, 1'b0);   // R6 ends in first half
    access(2'b01, N - 7, 4, 1'b1, 5'd4, 1'b1);   // R7 ends on serial tick
    access(2'b01, N - 9, 12, 1'b1, 5'd20, 1'b0); // R7 long
    access(2'b01, N - 3, 4, 1'b0, 5'd12, 1'b1);  // R1
    access(2'b01, 1, 5, 1'b1, 5'd30, 1'b1);      // R8
    // synchronous
    access(2'b10, N - 3, 3, 1'b1, 5'd5, 1'b1);   // R9/R10 in window same cell
    access(2'b11, N - 4, 6, 1'b1, 5'd6, 1'b0);   // R9

    // R10: strobe with select low is ignored
    begin
      int seen = 0;
      mode = 2'b00;
      @(negedge clk); host_cs = 1'b0; host_strb = 1'b1;
      for (int k = 0; k < 10; k++) begin
        tick();
        if (grant || busy || dtack) seen++;
      end
      @(negedge clk); host_strb = 1'b0;
      for (int k = 0; k < 4; k++) begin
        tick();
        if (grant || busy || dtack) seen++;
      end
      check(seen == 0, "R10", "select-low activity cycles", seen, 0);
    end

    for (int i = 0; i < 40; i++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      int p0 = $urandom_range(0, N - 1);
      int len = $urandom_range(1, 20);
      bit hit = 1'($urandom_range(0, 1));
      logic [AW-1:0] a = AW'($urandom_range(0, 31));
      bit wr = 1'($urandom_range(0, 1));
      access(m, p0, len, hit, a, wr);
    end

    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule